// File: doc/BRIEF.md
# Video Sync Timing Regenerator

This block takes raw active-low horizontal and vertical sync from a video source and turns them into clean, registered sync pulses. It works on a master clock that runs at twice the pixel rate. Each horizontal sync falling edge starts an output pulse of fixed length. A vertical sync falling edge is classed as first or second field. The class depends on whether a horizontal falling edge arrives at nearly the same moment. After that classification, the next line is marked with a vertical pulse that lasts exactly one line.

The block also drives a pixel-rate data strobe. The strobe toggles every master clock and is re-phased at each recognised horizontal falling edge. A select input can replace it with a strobe supplied from outside. A two-bit sync mode field decides whether the sync inputs are used at all. Only the value 00 lets edges through.

Top module: `vsr_top`

## Requirements
- R1: Both sync inputs pass through a two-stage synchronizer, and only falling edges are acted on. A horizontal falling edge driven before clock edge k makes `dhsync_n` low from clock edge k+2.
- R2: A vertical falling edge whose synchronized edge lies within one clock of a horizontal falling edge (earlier, same cycle or later) sets `field` to 0, meaning first field. Any other vertical falling edge sets `field` to 1, meaning second field. `field` takes its new value three clocks after the synchronized vertical edge.
- R3: `dhsync_n` goes low on every recognised horizontal falling edge and stays low for exactly 64 clocks (parameter `HPW`).
- R4: After a vertical falling edge, `dvsync_n` goes low together with `dhsync_n` on the first recognised horizontal falling edge at least two clocks after the vertical edge. It returns high together with the next horizontal falling edge, so it lasts one line.
- R5: With `ldv_sel` = 0, `ldv` stays low after reset until the first recognised horizontal falling edge. On the clock edge where `dhsync_n` goes low it is 1, and it then inverts on every clock.
- R6: With `ldv_sel` = 1, `ldv` equals `ext_ldv` with no register delay.
- R7: When `sync_mode` is not 00, sync input edges are ignored. No new horizontal or vertical pulse starts, `field` holds its value, and the internal strobe keeps toggling without being re-phased.
- R8: While reset is asserted, `dhsync_n` and `dvsync_n` are 1, `field` is 0 and `ldv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_n | input | 1 | Raw horizontal sync, active low |
| vsync_n | input | 1 | Raw vertical sync, active low |
| sync_mode | input | 2 | Sync source mode; 00 honours the inputs |
| ldv_sel | input | 1 | 1 selects the external strobe |
| ext_ldv | input | 1 | External pixel strobe |
| dhsync_n | output | 1 | Regenerated horizontal sync, active low |
| dvsync_n | output | 1 | Regenerated vertical sync, active low |
| field | output | 1 | 0 for first field, 1 for second field |
| ldv | output | 1 | Pixel data strobe |

## Verification
A wrong pulse counter shows on the ports as a horizontal pulse that is not 64 clocks wide. This is visible at the end of the first line. A wrong coincidence window or arming state shows up at the next vertical event. Either `field` reads the wrong value three clocks after the vertical edge, or the vertical pulse lands one line early or late. A strobe that is not re-phased shows as a wrong `ldv` value in the very first sample after a horizontal edge. The bench sweeps vertical offsets on both sides of the tolerance window.

// File: rtl/vsr_pkg.sv
`timescale 1ns/1ps
package vsr_pkg;
  localparam logic [1:0] SYNC_MODE_HONOUR = 2'b00;

  // Coincidence of a vertical edge with a horizontal edge one cycle either side.
  function automatic logic edges_coincide(logic h_before, logic h_same, logic h_after);
    return h_before | h_same | h_after;
  endfunction

  // Field code from the coincidence result: 0 = first field, 1 = second field.
  function automatic logic field_code(logic coincident);
    return ~coincident;
  endfunction

  // Next internal strobe value: forced high on a relock, otherwise inverted.
  function automatic logic strobe_next(logic cur, logic relock);
    return relock ? 1'b1 : ~cur;
  endfunction

  // True when a width counter holds its final value.
  function automatic logic count_at_end(int unsigned cnt, int unsigned width);
    return cnt == width - 1;
  endfunction
endpackage

// File: rtl/vsr_edge.sv
`timescale 1ns/1ps
module vsr_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  input  logic enable,
  output logic fall
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '1;
    else        shift_q <= {shift_q[DEPTH-2:0], din_n};
  end

  // Falling edge seen between the last synchronizer stage and the history flop.
  assign fall = enable & shift_q[DEPTH-1] & ~shift_q[DEPTH-2];
endmodule

// File: rtl/vsr_hpulse.sv
`timescale 1ns/1ps
module vsr_hpulse
  import vsr_pkg::*;
#(
  parameter int unsigned HPW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse_n
);
  localparam int unsigned CW = (HPW > 2) ? $clog2(HPW) : 1;

  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic          at_end;

  assign at_end = count_at_end(32'(cnt_q), HPW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (at_end) active_q <= 1'b0;
      else        cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign pulse_n = ~active_q;
endmodule

// File: rtl/vsr_vfield.sv
`timescale 1ns/1ps
module vsr_vfield
  import vsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hfall,
  input  logic vfall,
  output logic vdecide,
  output logic field,
  output logic dvsync_n
);
  logic hfall_d1, hfall_d2, vfall_d1;
  logic field_q, armed_q, inline_q;
  logic coincident;

  // The decision is taken one cycle after the vertical edge, so the horizontal
  // edge may precede it by one cycle, match it, or follow it by one cycle.
  assign vdecide    = vfall_d1;
  assign coincident = edges_coincide(hfall_d2, hfall_d1, hfall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hfall_d1 <= 1'b0;
      hfall_d2 <= 1'b0;
      vfall_d1 <= 1'b0;
    end else begin
      hfall_d1 <= hfall;
      hfall_d2 <= hfall_d1;
      vfall_d1 <= vfall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q  <= 1'b0;
      armed_q  <= 1'b0;
      inline_q <= 1'b0;
    end else begin
      if (vdecide) field_q <= field_code(coincident);
      if (hfall && armed_q) begin
        inline_q <= 1'b1;
        armed_q  <= vdecide;
      end else begin
        if (hfall) inline_q <= 1'b0;
        if (vdecide) armed_q <= 1'b1;
      end
    end
  end

  assign field    = field_q;
  assign dvsync_n = ~inline_q;
endmodule

// File: rtl/vsr_strobe.sv
`timescale 1ns/1ps
module vsr_strobe
  import vsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic relock,
  input  logic sel_ext,
  input  logic ext_strobe,
  output logic strobe_int,
  output logic running,
  output logic strobe
);
  logic int_q, run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (relock) run_q <= 1'b1;
      if (relock || run_q) int_q <= strobe_next(int_q, relock);
    end
  end

  assign strobe_int = int_q;
  assign running    = run_q;
  assign strobe     = sel_ext ? ext_strobe : int_q;
endmodule

// File: rtl/vsr_top.sv
`timescale 1ns/1ps
module vsr_top
  import vsr_pkg::*;
#(
  parameter int unsigned HPW       = 64,
  parameter int unsigned SYNC_FLOPS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_n,
  input  logic       vsync_n,
  input  logic [1:0] sync_mode,
  input  logic       ldv_sel,
  input  logic       ext_ldv,
  output logic       dhsync_n,
  output logic       dvsync_n,
  output logic       field,
  output logic       ldv
);
  localparam int unsigned NCH = 2;

  logic           honour;
  logic [NCH-1:0] raw_n;
  logic [NCH-1:0] falls;
  logic           hfall, vfall, vdecide;
  logic           ldv_int, ldv_run;

  assign honour = (sync_mode == SYNC_MODE_HONOUR);
  assign raw_n  = {vsync_n, hsync_n};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_edge
    vsr_edge #(.STAGES(SYNC_FLOPS)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .din_n  (raw_n[ch]),
      .enable (honour),
      .fall   (falls[ch])
    );
  end

  assign hfall = falls[0];
  assign vfall = falls[1];

  vsr_hpulse #(.HPW(HPW)) u_hpulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (hfall),
    .pulse_n (dhsync_n)
  );

  vsr_vfield u_vfield (
    .clk      (clk),
    .rst_n    (rst_n),
    .hfall    (hfall),
    .vfall    (vfall),
    .vdecide  (vdecide),
    .field    (field),
    .dvsync_n (dvsync_n)
  );

  vsr_strobe u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .relock     (hfall),
    .sel_ext    (ldv_sel),
    .ext_strobe (ext_ldv),
    .strobe_int (ldv_int),
    .running    (ldv_run),
    .strobe     (ldv)
  );
endmodule

// File: rtl/vsr_checker.sv
`timescale 1ns/1ps
module vsr_checker #(
  parameter int unsigned HPW = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hfall,
  input logic       vdecide,
  input logic       ldv_int,
  input logic       ldv_run,
  input logic [1:0] sync_mode,
  input logic       ldv_sel,
  input logic       ext_ldv,
  input logic       dhsync_n,
  input logic       dvsync_n,
  input logic       field,
  input logic       ldv
);
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= 0;
    else if (dhsync_n) low_cnt <= 0;
    else               low_cnt <= low_cnt + 1;
  end

  // R3: a recognised edge pulls the horizontal output low on the next clock
  a_r3_hpulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    hfall |=> !dhsync_n);

  // R3: every horizontal pulse ends after exactly HPW low clocks
  a_r3_hpulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dhsync_n) |-> (low_cnt == HPW));

  // R4: the vertical pulse begins only with a horizontal pulse
  a_r4_vpulse_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dvsync_n) |-> $fell(dhsync_n));

  // R2: field changes only right after a vertical decision cycle
  a_r2_field_update: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> $past(vdecide));

  // R5: internal strobe is high after a relock, then inverts every clock
  a_r5_strobe_relock: assert property (@(posedge clk) disable iff (!rst_n)
    hfall |=> ldv_int);
  a_r5_strobe_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (ldv_run && !hfall) |=> (ldv_int != $past(ldv_int)));

  // R6: external strobe passes straight through when selected
  a_r6_ext_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ldv_sel |-> (ldv == ext_ldv));

  // R7: no new horizontal pulse while sync inputs are disabled
  a_r7_mode_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    ((sync_mode != 2'b00) && dhsync_n) |=> dhsync_n);
endmodule

bind vsr_top vsr_checker #(.HPW(HPW)) u_vsr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hfall     (hfall),
  .vdecide   (vdecide),
  .ldv_int   (ldv_int),
  .ldv_run   (ldv_run),
  .sync_mode (sync_mode),
  .ldv_sel   (ldv_sel),
  .ext_ldv   (ext_ldv),
  .dhsync_n  (dhsync_n),
  .dvsync_n  (dvsync_n),
  .field     (field),
  .ldv       (ldv)
);

// File: tb/vsr_top_test.sv
`timescale 1ns/1ps
module vsr_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_n = 1'b1;
  logic       vsync_n = 1'b1;
  logic [1:0] sync_mode = 2'b00;
  logic       ldv_sel = 1'b0;
  logic       ext_ldv = 1'b0;
  logic       dhsync_n, dvsync_n, field, ldv;

  always #2.5 clk = ~clk;

  vsr_top uut (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .sync_mode(sync_mode), .ldv_sel(ldv_sel), .ext_ldv(ext_ldv),
    .dhsync_n(dhsync_n), .dvsync_n(dvsync_n), .field(field), .ldv(ldv)
  );

  localparam int HPW = 64;

  int checks = 0;
  int fails  = 0;
  int step   = 0;

  // Reference model state, all in bench steps (one step per falling clock edge).
  int pend_h  = -1;   // step at which the next horizontal pulse becomes visible
  bit pend_v  = 0;    // that pulse also opens the vertical pulse
  int eff_h   = -1;   // step at which the latest horizontal pulse became visible
  bit exp_dv  = 1;
  bit exp_fld = 0;
  int v_step  = -1000;
  bit v_pend  = 0;
  int fpend   = -1;
  bit fval    = 0;
  int last_h  = -1000;
  int vlow    = 0;
  bit hs_next = 1;
  bit ext_next = 0;

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s at step %0d: got %0b expected %0b", req, what, step, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic tick();
    bit vs_next;
    bit exp_dh, exp_ldv;
    @(negedge clk);
    if (step == pend_h) begin
      eff_h  = step;
      exp_dv = pend_v ? 1'b0 : 1'b1;
      pend_h = -1;
    end
    if (step == fpend) begin
      exp_fld = fval;
      fpend   = -1;
    end
    exp_dh  = !(eff_h >= 0 && (step - eff_h) < HPW);
    exp_ldv = ldv_sel ? ext_ldv : ((eff_h < 0) ? 1'b0 : (((step - eff_h) % 2) == 0));
    chk(dhsync_n, exp_dh,  "R1 R3", "dhsync_n");
    chk(dvsync_n, exp_dv,  "R4", "dvsync_n");
    chk(field,    exp_fld, "R2", "field");
    chk(ldv,      exp_ldv, ldv_sel ? "R6" : "R5", "ldv");

    vs_next = (vlow > 0) ? 1'b0 : 1'b1;
    if (vlow > 0) vlow--;
    if (sync_mode == 2'b00 && hsync_n && !hs_next) begin
      pend_h = step + 3;
      pend_v = v_pend && (step >= v_step + 2);
      if (pend_v) v_pend = 0;
      last_h = step;
      if (fpend >= 0 && step == v_step + 1) fval = 0;
    end
    if (sync_mode == 2'b00 && vsync_n && !vs_next) begin
      v_step = step;
      v_pend = 1;
      fpend  = step + 4;
      fval   = (last_h >= step - 1) ? 1'b0 : 1'b1;
    end
    hsync_n = hs_next;
    vsync_n = vs_next;
    ext_ldv = ext_next;
    step++;
  endtask

  // One line of L steps; vsync falls at index vidx (-1 for none).
  task automatic line(input int L, input int vidx);
    for (int i = 0; i < L; i++) begin
      hs_next  = (i < 6) ? 1'b0 : 1'b1;
      ext_next = ((step % 3) == 0);
      if (i == vidx) vlow = 20;
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) begin
      @(negedge clk);
      chk(dhsync_n, 1'b1, "R8", "dhsync_n in reset");
      chk(dvsync_n, 1'b1, "R8", "dvsync_n in reset");
      chk(field,    1'b0, "R8", "field in reset");
      chk(ldv,      1'b0, "R8", "ldv in reset");
    end
    rst_n = 1'b1;
    // R5: strobe low before the first edge, then locked
    for (int i = 0; i < 10; i++) begin
      hs_next = 1'b1;
      tick();
    end
    line(100, -1);
    line(100, -1);
    // R2/R4: sweep vertical offsets around the horizontal edge
    line(100, 0);   line(100, -1);            // coincident: first field
    line(100, 50);  line(100, -1);            // mid-line: second field
    line(100, 99);  line(100, -1); line(100, -1); // one before: first field
    line(100, 1);   line(100, -1);            // one after: first field
    line(100, 2);   line(100, -1);            // two after: second field
    line(130, 98);  line(130, -1);            // second field, longer line
    line(130, 0);   line(130, -1);            // first field
    line(80, 40);   line(80, -1);             // second field, short line
    // R7: sync inputs disabled
    sync_mode = 2'b01;
    line(100, 0);  line(100, 50);
    sync_mode = 2'b11;
    line(100, 0);  line(100, -1);
    sync_mode = 2'b00;
    line(100, -1); line(100, 0); line(100, -1);
    // R6: external strobe selected
    ldv_sel = 1'b1;
    line(90, -1); line(90, 45); line(90, -1);
    ldv_sel = 1'b0;
    line(100, -1);
    summary();
    $finish;
  end
endmodule